// File: doc/BRIEF.md
# Stack Return and Pop Sequencer

This block carries out the stack-reading part of an 8-bit processor's control flow. One command asks for one of these operations: a return that depends on a flag, an unconditional return, a return from an interrupt handler, a pop into a register pair, or a jump through HL. With each command the caller supplies the current zero and carry flags, the stack pointer and HL. The block decides whether the stack is read. When it is, it fetches two bytes from a byte-wide memory, one request per cycle, builds the 16-bit word and produces one result. The result gives the new stack pointer, the value to load, which register takes that value, and the instruction's cycle cost.

Commands arrive on a valid/ready stream. `cmd_ready` is high only while the block is idle, and a command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. Results leave on a second valid/ready stream. Once `res_valid` rises, it and every result field stay fixed until an edge where `res_ready` is high. No new command is accepted until that result has been taken. The memory port has no back-pressure: data for a request made in one cycle must be on `mem_rdata` during the next cycle. The block also holds a sticky interrupt master enable flag and gives a one-cycle completion pulse.

Top module: `stack_pop_seq`

## Requirements
- R1: `cmd_op` encodes the operation as follows: 0 return if Z clear, 1 return if Z set, 2 return if C clear, 3 return if C set, 4 unconditional return, 5 interrupt return, 6 pop into pair, 7 jump through HL. A command is accepted only on an edge where `cmd_valid` and `cmd_ready` are both high, and `cmd_ready` is high only while no command is in flight.
- R2: Each conditional return tests its own flag (`cmd_flag_z` or `cmd_flag_c`) in the sense its encoding gives. When the test passes, the result loads PC (`res_pc_load`=1) with the popped word.
- R3: A pop requests the low byte at SP and, in the next cycle, the high byte at SP+1. `mem_rdata` is sampled one cycle after each request. The word is {high, low}, and `res_sp` is SP+2 modulo 65536, so SP=0xFFFF reads 0xFFFF and then 0x0000 and returns SP 0x0001.
- R4: A conditional return whose test fails makes no memory request and returns `res_sp` equal to the given SP, `res_pc_load`=0, `res_pair_load`=0 and `res_word`=0.
- R5: `res_cycles` is 20 for a conditional return that is taken, 8 for one that is not taken, 16 for an unconditional or interrupt return, 12 for a pop and 4 for a jump through HL.
- R6: `ime` is 0 after reset and becomes 1 on the cycle after an interrupt-return result is taken. No other operation changes it.
- R7: A pop sets `res_pair_load`=1, `res_pc_load`=0 and `res_pair`=`cmd_pair` (0 BC, 1 DE, 2 HL, 3 AF). For pair 3 the four low bits of `res_word` are forced to zero.
- R8: A jump through HL returns `res_word`=`cmd_hl` with `res_pc_load`=1. It makes no memory request and leaves `res_sp` equal to the given SP.
- R9: While `res_valid` is high and `res_ready` is low, `res_valid` and all result fields hold their values.
- R10: `done` is high for exactly one cycle, the cycle after the edge on which a result is taken.
- R11: After reset `cmd_ready`=1, `res_valid`=0, `mem_req`=0, `done`=0 and `ime`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_op | input | 3 | Operation code (R1) |
| cmd_pair | input | 2 | Target pair for a pop |
| cmd_flag_z | input | 1 | Current zero flag |
| cmd_flag_c | input | 1 | Current carry flag |
| cmd_sp | input | 16 | Current stack pointer |
| cmd_hl | input | 16 | Current HL value |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_word | output | 16 | Value to load into PC or the pair |
| res_sp | output | 16 | Updated stack pointer |
| res_pc_load | output | 1 | PC takes `res_word` |
| res_pair_load | output | 1 | Pair `res_pair` takes `res_word` |
| res_pair | output | 2 | Pair selected for a pop |
| res_cycles | output | 5 | Instruction cycle cost |
| done | output | 1 | One-cycle completion pulse |
| ime | output | 1 | Interrupt master enable |

## Verification
The stack pointer or operation latched at acceptance could be wrong, or the sequencer could be left in the wrong state. In each case the fault shows on the very next result: a wrong `res_sp` or `res_cycles`, a word built from bytes at the wrong addresses, or a request count per command other than 0 or 2. Because every memory byte depends on its address, swapped or repeated fetch addresses change `res_word`. A controller that fails to return to idle stops `cmd_ready` and `done` from toggling within a few cycles. A stray interrupt-flag update shows on `ime` at the following completion.

// File: rtl/stack_pop_pkg.sv
package stack_pop_pkg;

  typedef enum logic [2:0] {
    OP_RET_NZ = 3'd0,
    OP_RET_Z  = 3'd1,
    OP_RET_NC = 3'd2,
    OP_RET_C  = 3'd3,
    OP_RET    = 3'd4,
    OP_RETI   = 3'd5,
    OP_POP    = 3'd6,
    OP_JP_HL  = 3'd7
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_LO,
    ST_RD_HI,
    ST_RD_LAST,
    ST_RESP
  } seq_state_e;

  localparam int CYC_W     = 5;
  localparam int CYC_JUMP  = 4;
  localparam int CYC_SKIP  = 8;
  localparam int CYC_POP   = 12;
  localparam int CYC_RET   = 16;
  localparam int CYC_TAKEN = 20;

  localparam logic [1:0] PAIR_AF = 2'd3;

  function automatic logic [CYC_W-1:0] cycle_cost(seq_op_e op, logic popped);
    case (op)
      OP_JP_HL:        return CYC_W'(CYC_JUMP);
      OP_POP:          return CYC_W'(CYC_POP);
      OP_RET, OP_RETI: return CYC_W'(CYC_RET);
      default:         return popped ? CYC_W'(CYC_TAKEN) : CYC_W'(CYC_SKIP);
    endcase
  endfunction

endpackage

// File: rtl/stack_pop_cond.sv
module stack_pop_cond
  import stack_pop_pkg::*;
(
  input  seq_op_e op,
  input  logic    flag_z,
  input  logic    flag_c,
  output logic    need_pop
);
  always_comb begin
    case (op)
      OP_RET_NZ: need_pop = ~flag_z;
      OP_RET_Z:  need_pop = flag_z;
      OP_RET_NC: need_pop = ~flag_c;
      OP_RET_C:  need_pop = flag_c;
      OP_JP_HL:  need_pop = 1'b0;
      default:   need_pop = 1'b1;
    endcase
  end
endmodule

// File: rtl/stack_pop_word.sv
module stack_pop_word #(
  parameter int DW        = 8,
  parameter int MASK_BITS = 4,
  localparam int WW       = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_lo,
  input  logic          cap_hi,
  input  logic          mask_low,
  input  logic [DW-1:0] rdata,
  output logic [WW-1:0] word
);
  localparam logic [DW-1:0] KEEP = {{(DW-MASK_BITS){1'b1}}, {MASK_BITS{1'b0}}};

  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (cap_lo) lo_q <= rdata;
      if (cap_hi) hi_q <= rdata;
    end
  end

  assign word = {hi_q, mask_low ? (lo_q & KEEP) : lo_q};

  // R3: the two capture strobes never coincide
  p_one_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cap_lo && cap_hi));
endmodule

// File: rtl/stack_pop_ctrl.sv
module stack_pop_ctrl
  import stack_pop_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          need_pop,
  input  logic          res_ready,
  input  logic [AW-1:0] sp_q,
  output logic          cmd_ready,
  output logic          cmd_fire,
  output logic          res_valid,
  output logic          res_fire,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          cap_lo,
  output logic          cap_hi
);
  seq_state_e state_q, state_d;

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign res_valid = (state_q == ST_RESP);
  assign res_fire  = res_valid && res_ready;
  assign mem_req   = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign mem_addr  = (state_q == ST_RD_HI) ? sp_q + AW'(1) : sp_q;
  assign cap_lo    = (state_q == ST_RD_HI);
  assign cap_hi    = (state_q == ST_RD_LAST);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (cmd_fire) state_d = need_pop ? ST_RD_LO : ST_RESP;
      ST_RD_LO:   state_d = ST_RD_HI;
      ST_RD_HI:   state_d = ST_RD_LAST;
      ST_RD_LAST: state_d = ST_RESP;
      ST_RESP:    if (res_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R3: the high-byte request follows the low-byte request at the next address
  p_lo_then_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_LO) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(1)));
  // R4: no memory traffic while idle or presenting a result
  p_quiet_port_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready || res_valid) |-> !mem_req);
  // R1: a command is never taken while a result is pending
  p_single_flight_r1: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !cmd_ready);
endmodule

// File: rtl/stack_pop_seq.sv
module stack_pop_seq
  import stack_pop_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [1:0]    cmd_pair,
  input  logic          cmd_flag_z,
  input  logic          cmd_flag_c,
  input  logic [AW-1:0] cmd_sp,
  input  logic [AW-1:0] cmd_hl,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_word,
  output logic [AW-1:0] res_sp,
  output logic          res_pc_load,
  output logic          res_pair_load,
  output logic [1:0]    res_pair,
  output logic [CYC_W-1:0] res_cycles,
  output logic          done,
  output logic          ime
);
  seq_op_e       op_in, op_q;
  logic          need_pop, pop_q;
  logic [1:0]    pair_q;
  logic [AW-1:0] sp_q, hl_q, word;
  logic          cmd_fire, res_fire, cap_lo, cap_hi;

  assign op_in = seq_op_e'(cmd_op);

  stack_pop_cond u_cond (
    .op       (op_in),
    .flag_z   (cmd_flag_z),
    .flag_c   (cmd_flag_c),
    .need_pop (need_pop)
  );

  stack_pop_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .need_pop  (need_pop),
    .res_ready (res_ready),
    .sp_q      (sp_q),
    .cmd_ready (cmd_ready),
    .cmd_fire  (cmd_fire),
    .res_valid (res_valid),
    .res_fire  (res_fire),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .cap_lo    (cap_lo),
    .cap_hi    (cap_hi)
  );

  stack_pop_word #(.DW(DW), .MASK_BITS(4)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_lo   (cap_lo),
    .cap_hi   (cap_hi),
    .mask_low ((op_q == OP_POP) && (pair_q == PAIR_AF)),
    .rdata    (mem_rdata),
    .word     (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_RET_NZ;
      pop_q  <= 1'b0;
      pair_q <= '0;
      sp_q   <= '0;
      hl_q   <= '0;
    end else if (cmd_fire) begin
      op_q   <= op_in;
      pop_q  <= need_pop;
      pair_q <= cmd_pair;
      sp_q   <= cmd_sp;
      hl_q   <= cmd_hl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      ime  <= 1'b0;
    end else begin
      done <= res_fire;
      if (res_fire && op_q == OP_RETI) ime <= 1'b1;
    end
  end

  assign res_pair_load = (op_q == OP_POP);
  assign res_pc_load   = (op_q == OP_JP_HL) || (pop_q && op_q != OP_POP);
  assign res_pair      = pair_q;
  assign res_sp        = pop_q ? sp_q + AW'(2) : sp_q;
  assign res_cycles    = cycle_cost(op_q, pop_q);
  always_comb begin
    if (op_q == OP_JP_HL) res_word = hl_q;
    else if (pop_q)       res_word = word;
    else                  res_word = '0;
  end

  // R9: result held under back-pressure
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_word) && $stable(res_sp)
                                   && $stable(res_cycles) && $stable(res_pc_load)
                                   && $stable(res_pair_load)));
  // R10: completion pulse lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6: the interrupt enable only ever rises
  p_ime_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ime |=> ime);
  // R4: a skipped return leaves SP as given
  p_skip_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pc_load && !res_pair_load) |-> (res_sp == sp_q && res_word == '0));
  // R7: AF pop clears the low flag nibble
  p_af_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pair_load && res_pair == PAIR_AF) |-> (res_word[3:0] == 4'h0));
  // R5: pops cost 12 cycles
  p_pop_cost_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_pair_load) |-> (res_cycles == CYC_W'(CYC_POP)));
endmodule

// File: tb/tb_stack_pop_seq.sv
module tb_stack_pop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_pair = '0;
  logic        cmd_flag_z = 1'b0, cmd_flag_c = 1'b0;
  logic [15:0] cmd_sp = '0, cmd_hl = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_word, res_sp;
  logic        res_pc_load, res_pair_load;
  logic [1:0]  res_pair;
  logic [4:0]  res_cycles;
  logic        done, ime;

  always #10 clk = ~clk;

  stack_pop_seq dut (.*);

  typedef struct {
    logic [15:0] word;
    logic [15:0] sp;
    logic        pc_load;
    logic        pair_load;
    logic [1:0]  pair;
    logic [4:0]  cycles;
    int          reads;
    logic        ime_after;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0, rd_cnt = 0, sent = 0, got = 0;
  logic exp_ime = 1'b0;
  bit finished = 0;

  function automatic logic [7:0] memf(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_rdata <= memf(mem_addr);
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: R1 encodings, computes the expected result from the requirements
  task automatic send(int op, int pair, bit z, bit c, logic [15:0] sp, logic [15:0] hl);
    exp_t e;
    bit taken;
    logic [15:0] w;
    case (op)
      0: taken = !z;
      1: taken = z;
      2: taken = !c;
      3: taken = c;
      7: taken = 0;
      default: taken = 1;
    endcase
    w = {memf(sp + 16'd1), memf(sp)};
    if (op == 6 && pair == 3) w[3:0] = 4'h0;
    e.pair      = 2'(pair);
    e.pair_load = (op == 6);
    e.pc_load   = (op == 7) || (taken && op != 6);
    e.reads     = taken ? 2 : 0;
    e.sp        = taken ? sp + 16'd2 : sp;
    e.word      = (op == 7) ? hl : (taken ? w : 16'h0);
    case (op)
      7: e.cycles = 5'd4;
      6: e.cycles = 5'd12;
      4, 5: e.cycles = 5'd16;
      default: e.cycles = taken ? 5'd20 : 5'd8;
    endcase
    if (op == 5) exp_ime = 1'b1;
    e.ime_after = exp_ime;
    q.push_back(e);
    sent++;
    @(negedge clk);
    cmd_op = 3'(op); cmd_pair = 2'(pair); cmd_flag_z = z; cmd_flag_c = c;
    cmd_sp = sp; cmd_hl = hl; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor: scoreboard compare with back-pressure
  initial begin
    int hold = 1;
    bit seen = 0, low_chk = 0;
    logic [15:0] s_word = '0, s_sp = '0;
    logic [4:0]  s_cyc = '0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (low_chk) begin
        chk(done == 1'b0, "R10", "done second cycle", done, 0);
        low_chk = 0;
      end
      if (res_valid && !res_ready) begin
        if (!seen) begin
          s_word = res_word; s_sp = res_sp; s_cyc = res_cycles; seen = 1;
        end else begin
          chk(res_word == s_word && res_sp == s_sp && res_cycles == s_cyc,
              "R9", "held result", {res_word, res_sp}, {s_word, s_sp});
        end
        if (hold > 0) hold--;
        else begin
          e = q.pop_front();
          chk(res_word == e.word, "R2/R3/R8", "word", res_word, e.word);
          chk(res_sp == e.sp, "R3/R4", "sp", res_sp, e.sp);
          chk(res_pc_load == e.pc_load, "R2/R4", "pc_load", res_pc_load, e.pc_load);
          chk(res_pair_load == e.pair_load, "R7", "pair_load", res_pair_load, e.pair_load);
          if (e.pair_load) chk(res_pair == e.pair, "R7", "pair", res_pair, e.pair);
          chk(res_cycles == e.cycles, "R5", "cycles", res_cycles, e.cycles);
          chk(rd_cnt == e.reads, "R3/R4", "read count", rd_cnt, e.reads);
          res_ready = 1'b1;
        end
      end else if (res_ready) begin
        res_ready = 1'b0;
        chk(done == 1'b1, "R10", "done pulse", done, 1);
        chk(ime == e.ime_after, "R6", "ime", ime, e.ime_after);
        chk(cmd_ready == 1'b1, "R1", "ready after result", cmd_ready, 1);
        low_chk = 1;
        rd_cnt = 0;
        seen = 0;
        got++;
        hold = got % 3;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cmd_ready == 1'b1, "R11", "cmd_ready", cmd_ready, 1);
    chk(res_valid == 1'b0, "R11", "res_valid", res_valid, 0);
    chk(mem_req == 1'b0, "R11", "mem_req", mem_req, 0);
    chk(done == 1'b0 && ime == 1'b0, "R11", "done/ime", {done, ime}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", "ready idle", cmd_ready, 1);
    send(0, 0, 0, 0, 16'hC000, 16'h1111); // R2 NZ taken
    send(0, 0, 1, 0, 16'hC010, 16'h1111); // R4 NZ skipped
    send(1, 0, 1, 0, 16'hC020, 16'h1111); // R2 Z taken
    send(1, 0, 0, 1, 16'hC030, 16'h1111); // R4 Z skipped
    send(2, 0, 0, 0, 16'hC040, 16'h1111); // R2 NC taken
    send(2, 0, 1, 1, 16'hC050, 16'h1111); // R4 NC skipped
    send(3, 0, 0, 1, 16'hC060, 16'h1111); // R2 C taken
    send(3, 0, 1, 0, 16'hC070, 16'h1111); // R4 C skipped
    send(4, 0, 1, 1, 16'hFFFF, 16'h2222); // R3 wrap
    send(6, 0, 0, 0, 16'hD100, 16'h0);    // R7 BC
    send(6, 1, 0, 0, 16'hD110, 16'h0);    // R7 DE
    send(6, 2, 0, 0, 16'hD120, 16'h0);    // R7 HL
    send(6, 3, 0, 0, 16'hD123, 16'h0);    // R7 AF masked
    send(7, 0, 0, 0, 16'hE000, 16'hBEEF); // R8 jump
    send(5, 0, 0, 0, 16'hE100, 16'h0);    // R6 interrupt return
    send(4, 0, 0, 0, 16'hE200, 16'h0);    // R6 stays set
    while (got < sent) @(negedge clk);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule